// File: doc/BRIEF.md
# TLB Fault Reporting Unit

This block sits behind the virtual-address translator of a processor core. On every cycle that the translator presents a result, the unit decides whether the access failed. A failing access is sorted into a load- or store-specific exception class, and the unit records the information the fault handler needs. That information is the complete faulting address, a page-table context pointer derived from it, and the virtual page pair number placed in the entry-high register.

The unit reports the class on a one-cycle exception strobe with a five-bit code. It also raises a separate refill flag, so that a missing mapping can be told apart from a mapping that exists but is not valid. A separate exception entry block uses these outputs to take the trap; this unit does not redirect the program counter.

Software reaches the three recorded registers through a select-and-read port. It may write the base field of the context register and the whole entry-high register through a select-and-write port.

Top module: `tlbf_unit`

## Requirements
- R1: While reset is high and after it, `exc_pulse` and `exc_refill` are 0 and all three registers read as zero. Read select 0 is the fault address, 1 is the context, 2 is entry-high, and 3 always reads zero.
- R2: Result code 1 (bad address) raises exception code 5 on a store and code 4 on a load, with refill clear. The undefined result codes 5, 6 and 7 are treated the same way.
- R3: Result code 2 (no matching entry) raises code 3 on a store and code 2 on a load, with `exc_refill` set. `exc_refill` is never high without `exc_pulse`.
- R4: Result code 3 (entry not valid) raises code 3 on a store and code 2 on a load, with refill clear.
- R5: Result code 4 (write to a clean page) raises code 1 for loads and stores alike, with refill clear.
- R6: Result code 0 (hit), or `req_valid` low, raises no exception and leaves all three registers unchanged.
- R7: `exc_pulse` is high for exactly the one cycle after each edge that samples a failing request. Back-to-back failing requests give back-to-back pulses.
- R8: On a fault, the fault-address register takes all 32 bits of `req_vaddr`.
- R9: On a fault, context bits 22:4 take `req_vaddr[31:13]`. Bits 31:23 keep their value, and bits 3:0 read zero.
- R10: On a fault, entry-high bits 31:13 take `req_vaddr[31:13]`. The ASID in bits 7:0 is kept, and bits 12:8 read zero.
- R11: A write with select 1 changes only context bits 31:23. A write with select 0 or 3 has no effect.
- R12: A write with select 2 loads entry-high bits 31:13 and 7:0. If a fault is sampled in the same cycle, the fault's update wins and the write is dropped. A context base write in that same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translator result present this cycle |
| req_result | input | 3 | Translator result code |
| req_vaddr | input | 32 | Virtual address of the access |
| req_store | input | 1 | 1 for a store, 0 for a load |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 2 | Register selected for writing |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_sel | input | 2 | Register selected for reading |
| sw_rd_data | output | 32 | Selected register value (combinational) |
| exc_pulse | output | 1 | One-cycle exception strobe |
| exc_code | output | 5 | Exception class, held until the next fault |
| exc_refill | output | 1 | Fault was a missing mapping |

## Verification
Each failing result class is applied once as a load and once as a store. This separates the load/store split of R2 and R4 from the direction-blind dirty class of R5, and separates the refill flag of R3 from the invalid class of R4. Addresses with all-ones, all-zero and mixed bits near bit 13 show whether the page-pair field is cut at the right position in both context and entry-high. Hit results and undefined codes are interleaved among the faults, and each one is followed by a read of every register. Directed cases then put a software write and a fault in the same cycle, write to the ignored selects, and apply reset in the middle of a run.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    typedef enum logic [2:0] {
        XR_HIT     = 3'd0,
        XR_BADADDR = 3'd1,
        XR_MISS    = 3'd2,
        XR_INVALID = 3'd3,
        XR_DIRTY   = 3'd4
    } xlat_res_e;

    typedef enum logic [4:0] {
        EXC_NONE    = 5'd0,
        EXC_MOD     = 5'd1,
        EXC_TLB_LD  = 5'd2,
        EXC_TLB_ST  = 5'd3,
        EXC_ADDR_LD = 5'd4,
        EXC_ADDR_ST = 5'd5
    } exc_code_e;

    typedef enum logic [1:0] {
        SEL_BADVA = 2'd0,
        SEL_CTX   = 2'd1,
        SEL_EHI   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      fault;
        logic      refill;
        exc_code_e code;
    } fault_t;

    // Sort a translator result into an exception class.
    function automatic fault_t classify(input logic [2:0] res, input logic store);
        fault_t f;
        f.fault  = 1'b1;
        f.refill = 1'b0;
        case (res)
            XR_HIT:     begin f.fault = 1'b0; f.code = EXC_NONE; end
            XR_MISS:    begin f.refill = 1'b1; f.code = store ? EXC_TLB_ST : EXC_TLB_LD; end
            XR_INVALID: f.code = store ? EXC_TLB_ST : EXC_TLB_LD;
            XR_DIRTY:   f.code = EXC_MOD;
            default:    f.code = store ? EXC_ADDR_ST : EXC_ADDR_LD;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tlbf_classifier.sv
module tlbf_classifier
    import tlbf_pkg::*;
(
    input  logic       req_valid,
    input  logic [2:0] req_result,
    input  logic       req_store,
    output fault_t     fault
);
    fault_t raw;

    always_comb begin
        raw = classify(req_result, req_store);
        fault = raw;
        if (!req_valid) begin
            fault.fault  = 1'b0;
            fault.refill = 1'b0;
            fault.code   = EXC_NONE;
        end
    end
endmodule

// File: rtl/tlbf_regs.sv
module tlbf_regs
    import tlbf_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PAGE_BITS    = 12,
    parameter int ASID_W       = 8,
    parameter int CTX_BASE_LSB = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_ld,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] bva_q,
    output logic [ADDR_W-1:0] ctx_q,
    output logic [ADDR_W-1:0] ehi_q
);
    localparam int VPN2_LSB   = PAGE_BITS + 1;
    localparam int VPN2_W     = ADDR_W - VPN2_LSB;
    localparam int CTX_BASE_W = ADDR_W - CTX_BASE_LSB;
    localparam int CTX_PAD_W  = CTX_BASE_LSB - VPN2_W;
    localparam int EHI_GAP_W  = VPN2_LSB - ASID_W;

    logic [ADDR_W-1:0]     badva_r;
    logic [CTX_BASE_W-1:0] ctx_base_r;
    logic [VPN2_W-1:0]     ctx_vpn_r;
    logic [VPN2_W-1:0]     ehi_vpn_r;
    logic [ASID_W-1:0]     ehi_asid_r;
    logic                  unused_wr_gap;

    assign unused_wr_gap = ^wr_data[VPN2_LSB-1:ASID_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            badva_r    <= '0;
            ctx_base_r <= '0;
            ctx_vpn_r  <= '0;
            ehi_vpn_r  <= '0;
            ehi_asid_r <= '0;
        end else begin
            if (fault_ld) begin
                badva_r   <= vaddr;
                ctx_vpn_r <= vaddr[ADDR_W-1:VPN2_LSB];
                ehi_vpn_r <= vaddr[ADDR_W-1:VPN2_LSB];
            end else if (wr_en && wr_sel == SEL_EHI) begin
                ehi_vpn_r  <= wr_data[ADDR_W-1:VPN2_LSB];
                ehi_asid_r <= wr_data[ASID_W-1:0];
            end
            if (wr_en && wr_sel == SEL_CTX)
                ctx_base_r <= wr_data[ADDR_W-1:CTX_BASE_LSB];
        end
    end

    assign bva_q = badva_r;
    assign ctx_q = {ctx_base_r, ctx_vpn_r, {CTX_PAD_W{1'b0}}};
    assign ehi_q = {ehi_vpn_r, {EHI_GAP_W{1'b0}}, ehi_asid_r};
endmodule

// File: rtl/tlbf_rdport.sv
module tlbf_rdport
    import tlbf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        rd_sel,
    input  logic [ADDR_W-1:0] bva_q,
    input  logic [ADDR_W-1:0] ctx_q,
    input  logic [ADDR_W-1:0] ehi_q,
    output logic [ADDR_W-1:0] rd_data
);
    always_comb begin
        case (rd_sel)
            SEL_BADVA: rd_data = bva_q;
            SEL_CTX:   rd_data = ctx_q;
            SEL_EHI:   rd_data = ehi_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tlbf_unit.sv
module tlbf_unit
    import tlbf_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PAGE_BITS    = 12,
    parameter int ASID_W       = 8,
    parameter int CTX_BASE_LSB = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_result,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_store,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_sel,
    input  logic [ADDR_W-1:0] sw_wr_data,
    input  logic [1:0]        sw_rd_sel,
    output logic [ADDR_W-1:0] sw_rd_data,
    output logic              exc_pulse,
    output logic [4:0]        exc_code,
    output logic              exc_refill
);
    fault_t            cur_fault;
    logic [ADDR_W-1:0] bva_q;
    logic [ADDR_W-1:0] ctx_q;
    logic [ADDR_W-1:0] ehi_q;
    logic              pulse_r;
    logic              refill_r;
    exc_code_e         code_r;

    tlbf_classifier u_cls (
        .req_valid (req_valid),
        .req_result(req_result),
        .req_store (req_store),
        .fault     (cur_fault)
    );

    tlbf_regs #(
        .ADDR_W      (ADDR_W),
        .PAGE_BITS   (PAGE_BITS),
        .ASID_W      (ASID_W),
        .CTX_BASE_LSB(CTX_BASE_LSB)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .fault_ld(cur_fault.fault),
        .vaddr   (req_vaddr),
        .wr_en   (sw_wr_en),
        .wr_sel  (sw_wr_sel),
        .wr_data (sw_wr_data),
        .bva_q   (bva_q),
        .ctx_q   (ctx_q),
        .ehi_q   (ehi_q)
    );

    tlbf_rdport #(.ADDR_W(ADDR_W)) u_rd (
        .rd_sel (sw_rd_sel),
        .bva_q  (bva_q),
        .ctx_q  (ctx_q),
        .ehi_q  (ehi_q),
        .rd_data(sw_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_r  <= 1'b0;
            refill_r <= 1'b0;
            code_r   <= EXC_NONE;
        end else begin
            pulse_r  <= cur_fault.fault;
            refill_r <= cur_fault.fault & cur_fault.refill;
            if (cur_fault.fault)
                code_r <= cur_fault.code;
        end
    end

    assign exc_pulse  = pulse_r;
    assign exc_refill = refill_r;
    assign exc_code   = code_r;
endmodule

// File: rtl/tlbf_unit_chk.sv
module tlbf_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_result,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              exc_pulse,
    input logic [4:0]        exc_code,
    input logic              exc_refill,
    input logic [ADDR_W-1:0] bva_q
);
    logic failing;
    assign failing = req_valid && (req_result != 3'd0);

    p_fault_pulses_r7: assert property (@(posedge clk) disable iff (rst)
        failing |=> exc_pulse);

    p_quiet_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
        !failing |=> !exc_pulse);

    p_refill_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_result == 3'd2) |=> exc_refill);

    p_refill_gated_r3: assert property (@(posedge clk) disable iff (rst)
        exc_refill |-> exc_pulse);

    p_dirty_code_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_result == 3'd4) |=> (exc_code == 5'd1 && !exc_refill));

    p_badva_load_r8: assert property (@(posedge clk) disable iff (rst)
        failing |=> bva_q == $past(req_vaddr));

    p_badva_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !failing |=> $stable(bva_q));
endmodule

bind tlbf_unit tlbf_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_result(req_result),
    .req_vaddr (req_vaddr),
    .exc_pulse (exc_pulse),
    .exc_code  (exc_code),
    .exc_refill(exc_refill),
    .bva_q     (bva_q)
);

// File: tb/tlbf_unit_tb_top.sv
module tlbf_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [2:0]  res;
        logic        st;
        logic [31:0] va;
        logic [4:0]  code;
        logic        refill;
        logic        pulse;
    } vec_t;

    // R2..R6 stimulus table
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 1'b0, 32'h8000_1234, 5'd4, 1'b0, 1'b1},
        '{3'd1, 1'b1, 32'hC000_0010, 5'd5, 1'b0, 1'b1},
        '{3'd2, 1'b0, 32'h0040_3ABC, 5'd2, 1'b1, 1'b1},
        '{3'd2, 1'b1, 32'h7FFF_E000, 5'd3, 1'b1, 1'b1},
        '{3'd3, 1'b0, 32'h1234_5678, 5'd2, 1'b0, 1'b1},
        '{3'd3, 1'b1, 32'hDEAD_BEEF, 5'd3, 1'b0, 1'b1},
        '{3'd4, 1'b0, 32'h0000_2FFF, 5'd1, 1'b0, 1'b1},
        '{3'd4, 1'b1, 32'hFFFF_FFFF, 5'd1, 1'b0, 1'b1},
        '{3'd0, 1'b1, 32'h5555_5555, 5'd0, 1'b0, 1'b0},
        '{3'd6, 1'b0, 32'h0ABC_D000, 5'd4, 1'b0, 1'b1},
        '{3'd7, 1'b1, 32'h0000_0000, 5'd5, 1'b0, 1'b1},
        '{3'd0, 1'b0, 32'hAAAA_AAAA, 5'd0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_result;
    logic [31:0] req_vaddr;
    logic        req_store;
    logic        sw_wr_en;
    logic [1:0]  sw_wr_sel;
    logic [31:0] sw_wr_data;
    logic [1:0]  sw_rd_sel;
    logic [31:0] sw_rd_data;
    logic        exc_pulse;
    logic [4:0]  exc_code;
    logic        exc_refill;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of register contents
    logic [31:0] m_bva;
    logic [8:0]  m_base;
    logic [18:0] m_ctx_vpn;
    logic [18:0] m_ehi_vpn;
    logic [7:0]  m_asid;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbf_unit dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_result(req_result),
        .req_vaddr(req_vaddr), .req_store(req_store),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .sw_rd_sel(sw_rd_sel), .sw_rd_data(sw_rd_data),
        .exc_pulse(exc_pulse), .exc_code(exc_code), .exc_refill(exc_refill)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] d);
        sw_rd_sel = sel;
        #1;
        d = sw_rd_data;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        read_reg(2'd0, d);
        check({tag, " R8 badva"}, d, m_bva);
        read_reg(2'd1, d);
        check({tag, " R9 ctx"}, d, {m_base, m_ctx_vpn, 4'h0});
        read_reg(2'd2, d);
        check({tag, " R10 ehi"}, d, {m_ehi_vpn, 5'h0, m_asid});
    endtask

    task automatic model_fault(input logic [31:0] va);
        m_bva     = va;
        m_ctx_vpn = va[31:13];
        m_ehi_vpn = va[31:13];
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = data;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; req_valid = 1'b0; req_result = '0; req_vaddr = '0; req_store = 1'b0;
        sw_wr_en = 1'b0; sw_wr_sel = '0; sw_wr_data = '0; sw_rd_sel = '0;
        m_bva = '0; m_base = '0; m_ctx_vpn = '0; m_ehi_vpn = '0; m_asid = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pulse", {31'b0, exc_pulse}, 32'd0);
        check("R1 refill", {31'b0, exc_refill}, 32'd0);
        check_regs("R1 reset");
        rst = 1'b0;

        // R11 context base write, R12 entry-high write, select 0 ignored
        sw_write(2'd1, 32'hFFFF_FFFF);
        m_base = 9'h1FF;
        sw_write(2'd2, 32'hFFFF_FFFF);
        m_ehi_vpn = 19'h7FFFF; m_asid = 8'hFF;
        sw_write(2'd0, 32'h1234_5678);
        sw_write(2'd3, 32'h8765_4321);
        check_regs("R11/R12 sw write");
        read_reg(2'd3, d);
        check("R1 sel3 reads zero", d, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_result = VECS[i].res;
            req_store = VECS[i].st; req_vaddr = VECS[i].va;
            @(negedge clk);
            req_valid = 1'b0;
            if (VECS[i].pulse) model_fault(VECS[i].va);
            check($sformatf("R7 pulse vec%0d", i), {31'b0, exc_pulse}, {31'b0, VECS[i].pulse});
            if (VECS[i].pulse) begin
                check($sformatf("R2-5 code vec%0d", i), {27'b0, exc_code}, {27'b0, VECS[i].code});
                check($sformatf("R3/R4 refill vec%0d", i), {31'b0, exc_refill}, {31'b0, VECS[i].refill});
            end
            check_regs($sformatf("R6 vec%0d", i));
        end

        // R7 back-to-back faults
        @(negedge clk);
        req_valid = 1'b1; req_result = 3'd2; req_store = 1'b0; req_vaddr = 32'h0100_0000;
        @(negedge clk);
        req_result = 3'd3; req_store = 1'b1; req_vaddr = 32'h0200_0000;
        check("R7 first pulse", {31'b0, exc_pulse}, 32'd1);
        check("R3 first refill", {31'b0, exc_refill}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second pulse", {31'b0, exc_pulse}, 32'd1);
        check("R4 second code", {27'b0, exc_code}, 32'd3);
        check("R4 second refill", {31'b0, exc_refill}, 32'd0);
        @(negedge clk);
        check("R7 pulse ends", {31'b0, exc_pulse}, 32'd0);
        model_fault(32'h0200_0000);
        check_regs("R7 b2b");

        // R6 request with valid low carries a failing code
        @(negedge clk);
        req_valid = 1'b0; req_result = 3'd1; req_vaddr = 32'hFEED_0000;
        @(negedge clk);
        check("R6 invalid req no pulse", {31'b0, exc_pulse}, 32'd0);
        check_regs("R6 valid low");

        // R12 fault and entry-high write in the same cycle: fault wins
        @(negedge clk);
        req_valid = 1'b1; req_result = 3'd3; req_store = 1'b0; req_vaddr = 32'h1357_9BDF;
        sw_wr_en = 1'b1; sw_wr_sel = 2'd2; sw_wr_data = 32'h0000_003C;
        @(negedge clk);
        req_valid = 1'b0; sw_wr_en = 1'b0;
        model_fault(32'h1357_9BDF);
        check("R12 collide pulse", {31'b0, exc_pulse}, 32'd1);
        check_regs("R12 ehi collide");

        // R12 fault and context base write in the same cycle: both apply
        @(negedge clk);
        req_valid = 1'b1; req_result = 3'd2; req_store = 1'b1; req_vaddr = 32'h2468_ACE0;
        sw_wr_en = 1'b1; sw_wr_sel = 2'd1; sw_wr_data = 32'h0280_0000;
        @(negedge clk);
        req_valid = 1'b0; sw_wr_en = 1'b0;
        model_fault(32'h2468_ACE0);
        m_base = 9'h005;
        check_regs("R12 ctx collide");

        // R1 reset in mid-run
        @(negedge clk);
        req_valid = 1'b1; req_result = 3'd4; req_vaddr = 32'h3333_3333;
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        m_bva = '0; m_base = '0; m_ctx_vpn = '0; m_ehi_vpn = '0; m_asid = '0;
        check("R1 mid reset pulse", {31'b0, exc_pulse}, 32'd0);
        check_regs("R1 mid reset");
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule